// File: doc/BRIEF.md
# UART Register Front End with Receive and Transmit FIFOs

This block sits between a 32-bit memory-mapped bus and a pair of external serial engines. It holds the serial line setup word and buffers received bytes and bytes waiting to be sent in two internal power-of-two FIFOs. Through four word registers, software reads a FIFO health summary, pops received bytes together with their error flags, and queues bytes for transmission or forces a line break. The block drives four interrupt lines that software can use to service the link without polling.

The receive engine hands over each byte with a one-cycle strobe and its error flags. The transmit engine takes a byte when the block's strobe is high and the engine is not busy. The block does no serial timing of its own. It passes the setup word to both engines and pulses a receiver reset whenever the receive path is cleared.

Top module: `uart_regfile`

## Requirements
- R1: `bus_addr_i` selects a register: 0 is setup, 1 is FIFO status, 2 is receive data, 3 is transmit data. `bus_ack_o` rises exactly two clocks after a cycle with `bus_stb_i` high. For a read, `bus_rdata_o` carries the register value as it was in the strobe cycle. `bus_stall_o` is always low.
- R2: The setup register is 30 bits wide, reads back zero-extended, resets to `SETUP_INIT` and drives `setup_o`. A write to it clears the receive FIFO and its overflow flag, and pulses `rx_reset_o` high for the following cycle.
- R3: The status word holds transmit information in bits 31:16 and receive information in bits 15:0. Each half is laid out as {log2 depth[3:0], fill[9:0], at-least-half-full, non-empty}.
- R4: The receive data word is {19'b0, overflow, break (live `rx_break_i`), frame error, parity error, empty, byte[7:0]}. The byte field reads 0 when the FIFO is empty. A read pops one entry only if the FIFO is non-empty.
- R5: The parity-error (bit 9) and frame-error (bit 10) flags become set on a receive strobe that carries that error. Each stays set until software writes a 1 to its bit at address 2. If a set and a clear arrive in the same cycle, the set wins.
- R6: A push into a full FIFO drops the new entry and sets that direction's overflow flag. Writing a 1 to bit 12 at address 2 clears the receive FIFO and its overflow flag and pulses `rx_reset_o`.
- R7: The transmit data word is {17'b0, at-least-half-full, empty, overflow, `rx_line_i`, `tx_line_i`, break state, busy, last byte handed to the engine}. Busy means the engine is busy, a hand-off is pending, or the FIFO holds data.
- R8: Every write to address 3 sets the break state to bit 9. A write pushes byte[7:0] only if bits 9 and 12 are clear and the block was not already in break. Writing a 1 to bit 12 clears the transmit FIFO and its overflow flag.
- R9: While not in break, the head of the transmit FIFO is popped onto `tx_data_o` with `tx_stb_o` high. The strobe and data hold until a cycle with `tx_busy_i` low, and the strobe then drops for at least one cycle.
- R10: `irq_rx_o` is high while the receive FIFO is non-empty. `irq_rxfifo_o` is high while that FIFO is at least half full. `irq_txfifo_o` is high while the transmit FIFO is less than half full. `irq_tx_o` is high while the transmit busy bit of R7 is low.
- R11: Writes to the status register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_stb_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 2 | Word register select |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Acknowledge, two clocks after strobe |
| bus_stall_o | output | 1 | Always low |
| bus_rdata_o | output | 32 | Read data, valid with acknowledge |
| setup_o | output | 30 | Setup word for both engines |
| rx_stb_i | input | 1 | Receive engine byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Receive line in break |
| rx_parity_err_i | input | 1 | Parity error on this byte |
| rx_frame_err_i | input | 1 | Frame error on this byte |
| rx_line_i | input | 1 | Receive line level |
| rx_reset_o | output | 1 | Receiver reset pulse |
| tx_stb_o | output | 1 | Byte ready for transmit engine |
| tx_data_o | output | 8 | Byte for transmit engine |
| tx_busy_i | input | 1 | Transmit engine busy |
| tx_break_o | output | 1 | Force break on transmit line |
| tx_line_i | input | 1 | Transmit line level |
| irq_rx_o | output | 1 | Receive byte available |
| irq_tx_o | output | 1 | Transmit path idle |
| irq_rxfifo_o | output | 1 | Receive FIFO at least half full |
| irq_txfifo_o | output | 1 | Transmit FIFO below half full |

## Verification
The bench drives the receive FIFO past full. A design that wrapped its pointers would overwrite buffered bytes, and one that lost the overflow flag would report no error. It reads the empty receive FIFO repeatedly, where a pop without a guard would corrupt the fill count. It clears sticky errors and both FIFOs through write-one bits, and writes the status register, which must change nothing. It fills the transmit FIFO behind a slow engine and toggles break around queued bytes. Here a leak shows up as a byte handed over during break, or as a byte pushed by the write meant to leave break.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  typedef enum logic [1:0] {
    ADDR_SETUP  = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_RXDATA = 2'd2,
    ADDR_TXDATA = 2'd3
  } reg_addr_e;

  localparam int unsigned SETUP_W  = 30;
  localparam int unsigned FILL_W   = 10;

  // receive data word bits
  localparam int unsigned RX_PAR_BIT = 9;
  localparam int unsigned RX_FRM_BIT = 10;
  localparam int unsigned RX_RST_BIT = 12;

  // transmit data word bits
  localparam int unsigned TX_BRK_BIT = 9;
  localparam int unsigned TX_CLR_BIT = 12;

  function automatic logic [15:0] status_half(input logic [3:0] lg,
                                              input logic [FILL_W-1:0] fill,
                                              input logic half,
                                              input logic nonempty);
    return {lg, fill, half, nonempty};
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned DW = 8,
  parameter int unsigned LG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          half_o,
  output logic [LG:0]   fill_o,
  output logic          ovf_o
);
  localparam int unsigned DEPTH = 1 << LG;

  logic [DW-1:0] mem_q [DEPTH];
  logic [LG-1:0] wptr_q, rptr_q;
  logic [LG:0]   cnt_q;
  logic          ovf_q;
  logic          full, do_pop, do_push;

  assign full    = (cnt_q == (LG+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot for a push into a full fifo
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign half_o  = (cnt_q >= (LG+1)'(DEPTH/2));
  assign fill_o  = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/uart_tx_feed.sv
module uart_tx_feed #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          brk_i,
  input  logic          empty_i,
  input  logic [DW-1:0] head_i,
  input  logic          busy_i,
  output logic          pop_o,
  output logic          stb_o,
  output logic [DW-1:0] data_o
);
  logic          stb_q;
  logic [DW-1:0] data_q;

  assign pop_o = !stb_q && !empty_i && !brk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      data_q <= '0;
    end else if (stb_q && !busy_i) begin
      stb_q <= 1'b0;
    end else if (pop_o) begin
      stb_q  <= 1'b1;
      data_q <= head_i;
    end
  end

  assign stb_o  = stb_q;
  assign data_o = data_q;
endmodule

// File: rtl/uart_bus_port.sv
module uart_bus_port #(
  parameter int unsigned DW      = 32,
  parameter int unsigned ACK_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);
  logic          ack_q [ACK_LAT];
  logic [DW-1:0] rd_q  [ACK_LAT];

  for (genvar g = 0; g < ACK_LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ack_q[g] <= 1'b0;
        rd_q[g]  <= '0;
      end else if (g == 0) begin
        ack_q[g] <= stb_i;
        rd_q[g]  <= rdata_i;
      end else begin
        ack_q[g] <= ack_q[g-1];
        rd_q[g]  <= rd_q[g-1];
      end
    end
  end

  assign ack_o   = ack_q[ACK_LAT-1];
  assign rdata_o = rd_q[ACK_LAT-1];
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int unsigned       LG_RX      = 4,
  parameter int unsigned       LG_TX      = 4,
  parameter logic [SETUP_W-1:0] SETUP_INIT = 30'd434
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_stb_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic               bus_ack_o,
  output logic               bus_stall_o,
  output logic [31:0]        bus_rdata_o,
  output logic [SETUP_W-1:0] setup_o,
  input  logic               rx_stb_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_break_i,
  input  logic               rx_parity_err_i,
  input  logic               rx_frame_err_i,
  input  logic               rx_line_i,
  output logic               rx_reset_o,
  output logic               tx_stb_o,
  output logic [7:0]         tx_data_o,
  input  logic               tx_busy_i,
  output logic               tx_break_o,
  input  logic               tx_line_i,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_rxfifo_o,
  output logic               irq_txfifo_o
);
  localparam int unsigned BYTE_W = 8;

  initial begin
    if (LG_RX < 1 || LG_RX > 9 || LG_TX < 1 || LG_TX > 9)
      $error("fifo log2 depth must be 1..9");
  end

  reg_addr_e addr;
  logic      wr, rd;
  assign addr = reg_addr_e'(bus_addr_i);
  assign wr   = bus_stb_i && bus_we_i;
  assign rd   = bus_stb_i && !bus_we_i;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[31:30]};

  // setup
  logic [SETUP_W-1:0] setup_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  setup_q <= SETUP_INIT;
    else if (wr && addr == ADDR_SETUP) setup_q <= bus_wdata_i[SETUP_W-1:0];
  end
  assign setup_o = setup_q;

  // receive path
  logic            rx_clr, rx_pop;
  logic [BYTE_W-1:0] rx_head;
  logic            rx_empty, rx_half, rx_ovf;
  logic [LG_RX:0]  rx_fill;
  logic            par_q, frm_q, rx_rst_q;

  assign rx_clr = wr && (addr == ADDR_SETUP ||
                         (addr == ADDR_RXDATA && bus_wdata_i[RX_RST_BIT]));
  assign rx_pop = rd && addr == ADDR_RXDATA;

  uart_fifo #(.DW(BYTE_W), .LG(LG_RX)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .push_i  (rx_stb_i),
    .wdata_i (rx_data_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .half_o  (rx_half),
    .fill_o  (rx_fill),
    .ovf_o   (rx_ovf)
  );

  logic clr_par, clr_frm;
  assign clr_par = wr && addr == ADDR_RXDATA && bus_wdata_i[RX_PAR_BIT];
  assign clr_frm = wr && addr == ADDR_RXDATA && bus_wdata_i[RX_FRM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q    <= 1'b0;
      frm_q    <= 1'b0;
      rx_rst_q <= 1'b0;
    end else begin
      // set wins over clear
      par_q    <= (par_q && !clr_par) || (rx_stb_i && rx_parity_err_i);
      frm_q    <= (frm_q && !clr_frm) || (rx_stb_i && rx_frame_err_i);
      rx_rst_q <= rx_clr;
    end
  end
  assign rx_reset_o = rx_rst_q;

  // transmit path
  logic              tx_wr, tx_clr, tx_push, tx_pop;
  logic [BYTE_W-1:0] tx_head;
  logic              tx_empty, tx_half, tx_ovf;
  logic [LG_TX:0]    tx_fill;
  logic              brk_q, tx_busy_bit;

  assign tx_wr   = wr && addr == ADDR_TXDATA;
  assign tx_clr  = tx_wr && bus_wdata_i[TX_CLR_BIT];
  assign tx_push = tx_wr && !bus_wdata_i[TX_CLR_BIT] && !bus_wdata_i[TX_BRK_BIT] && !brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    brk_q <= 1'b0;
    else if (tx_wr) brk_q <= bus_wdata_i[TX_BRK_BIT];
  end
  assign tx_break_o = brk_q;

  uart_fifo #(.DW(BYTE_W), .LG(LG_TX)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_clr),
    .push_i  (tx_push),
    .wdata_i (bus_wdata_i[BYTE_W-1:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .half_o  (tx_half),
    .fill_o  (tx_fill),
    .ovf_o   (tx_ovf)
  );

  uart_tx_feed #(.DW(BYTE_W)) i_tx_feed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .brk_i   (brk_q),
    .empty_i (tx_empty),
    .head_i  (tx_head),
    .busy_i  (tx_busy_i),
    .pop_o   (tx_pop),
    .stb_o   (tx_stb_o),
    .data_o  (tx_data_o)
  );

  assign tx_busy_bit = tx_busy_i || tx_stb_o || !tx_empty;

  // read mux
  logic [31:0] rd_mux;
  always_comb begin
    unique case (addr)
      ADDR_SETUP:  rd_mux = {{(32-SETUP_W){1'b0}}, setup_q};
      ADDR_STATUS: rd_mux = {status_half(4'(LG_TX), FILL_W'(tx_fill), tx_half, !tx_empty),
                             status_half(4'(LG_RX), FILL_W'(rx_fill), rx_half, !rx_empty)};
      ADDR_RXDATA: rd_mux = {19'b0, rx_ovf, rx_break_i, frm_q, par_q, rx_empty,
                             rx_empty ? 8'h00 : rx_head};
      default:     rd_mux = {17'b0, tx_half, tx_empty, tx_ovf, rx_line_i, tx_line_i,
                             brk_q, tx_busy_bit, tx_data_o};
    endcase
  end

  uart_bus_port #(.DW(32), .ACK_LAT(2)) i_bus_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (bus_stb_i),
    .rdata_i (rd_mux),
    .ack_o   (bus_ack_o),
    .rdata_o (bus_rdata_o)
  );
  assign bus_stall_o = 1'b0;

  // interrupts
  assign irq_rx_o     = !rx_empty;
  assign irq_rxfifo_o = rx_half;
  assign irq_txfifo_o = !tx_half;
  assign irq_tx_o     = !tx_busy_bit;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_stb_i,
  input logic       bus_we_i,
  input logic [1:0] bus_addr_i,
  input logic       bus_ack_o,
  input logic       bus_stall_o,
  input logic       rx_reset_o,
  input logic       tx_stb_o,
  input logic [7:0] tx_data_o,
  input logic       tx_busy_i,
  input logic       tx_break_o,
  input logic       irq_rx_o,
  input logic       irq_tx_o,
  input logic       irq_rxfifo_o
);
  a_r1_ack_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_i |-> ##2 bus_ack_o);

  a_r1_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_stall_o);

  a_r2_setup_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_i && bus_we_i && bus_addr_i == 2'd0) |=> rx_reset_o);

  a_r8_no_load_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_break_o && !tx_stb_o) |=> !tx_stb_o);

  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stb_o && tx_busy_i) |=> (tx_stb_o && $stable(tx_data_o)));

  a_r10_tx_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_o |-> (!tx_busy_i && !tx_stb_o));

  a_r10_rxfifo_implies_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rxfifo_o |-> irq_rx_o);
endmodule

bind uart_regfile uart_regfile_chk i_chk (.*);

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
  localparam int LG = 4;
  localparam int D  = 1 << LG;
  localparam logic [29:0] SINIT = 30'd434;
  localparam int ENG_CYC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        stb = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        rx_stb = 0, rx_brk = 0, rx_par = 0, rx_frm = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_line = 1, tx_line = 1, tx_busy = 0;

  logic        ack, stall, rx_rst, tx_stb, tx_brk;
  logic [31:0] rdata;
  logic [29:0] setup;
  logic [7:0]  tx_data;
  logic        irq_rx, irq_tx, irq_rxf, irq_txf;

  uart_regfile #(.LG_RX(LG), .LG_TX(LG), .SETUP_INIT(SINIT)) i_uart_regfile (
    .clk_i(clk), .rst_ni(rst_n), .bus_stb_i(stb), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_ack_o(ack), .bus_stall_o(stall), .bus_rdata_o(rdata),
    .setup_o(setup), .rx_stb_i(rx_stb), .rx_data_i(rx_data), .rx_break_i(rx_brk),
    .rx_parity_err_i(rx_par), .rx_frame_err_i(rx_frm), .rx_line_i(rx_line),
    .rx_reset_o(rx_rst), .tx_stb_o(tx_stb), .tx_data_o(tx_data), .tx_busy_i(tx_busy),
    .tx_break_o(tx_brk), .tx_line_i(tx_line), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_rxfifo_o(irq_rxf), .irq_txfifo_o(irq_txf));

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  rxq[$], txq[$];
  bit          m_rx_ovf, m_tx_ovf, m_par, m_frm, m_brk, m_txstb, m_rxrst;
  logic [7:0]  m_txdata;
  logic [29:0] m_setup;
  bit          p_ack[2], p_we[2];
  logic [1:0]  p_addr[2];
  logic [31:0] p_rd[2];

  function automatic bit m_busy();
    return tx_busy || m_txstb || (txq.size() != 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {2'b0, m_setup};
      2'd1: return {4'(LG), 10'(txq.size()), txq.size() >= D/2, txq.size() != 0,
                    4'(LG), 10'(rxq.size()), rxq.size() >= D/2, rxq.size() != 0};
      2'd2: return {19'b0, m_rx_ovf, rx_brk, m_frm, m_par, rxq.size() == 0,
                    (rxq.size() != 0) ? rxq[0] : 8'h00};
      default: return {17'b0, txq.size() >= D/2, txq.size() == 0, m_tx_ovf, rx_line,
                       tx_line, m_brk, m_busy(), m_txdata};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      m_rx_ovf = 0; m_tx_ovf = 0; m_par = 0; m_frm = 0; m_brk = 0;
      m_txstb = 0; m_rxrst = 0; m_txdata = 0; m_setup = SINIT;
      for (int i = 0; i < 2; i++) begin
        p_ack[i] = 0; p_we[i] = 0; p_addr[i] = 0; p_rd[i] = 0;
      end
    end else begin
      bit wr, rx_clr, rx_pop, tx_clr, push_req, feed_pop, acc;
      int osz;
      logic [31:0] rv;
      rv = m_read(addr);
      wr = stb && we;
      p_ack[1] = p_ack[0]; p_we[1] = p_we[0]; p_addr[1] = p_addr[0]; p_rd[1] = p_rd[0];
      p_ack[0] = stb; p_we[0] = we; p_addr[0] = addr; p_rd[0] = rv;
      // receive side
      rx_clr = wr && (addr == 0 || (addr == 2 && wdata[12]));
      osz = rxq.size();
      rx_pop = stb && !we && addr == 2 && osz > 0;
      acc = rx_stb && (osz < D || rx_pop);
      if (rx_pop) void'(rxq.pop_front());
      if (acc) rxq.push_back(rx_data);
      if (rx_stb && !acc) m_rx_ovf = 1;
      if (rx_clr) begin rxq.delete(); m_rx_ovf = 0; end
      m_par = (m_par && !(wr && addr == 2 && wdata[9])) || (rx_stb && rx_par);
      m_frm = (m_frm && !(wr && addr == 2 && wdata[10])) || (rx_stb && rx_frm);
      m_rxrst = rx_clr;
      if (wr && addr == 0) m_setup = wdata[29:0];
      // transmit side
      tx_clr = wr && addr == 3 && wdata[12];
      push_req = wr && addr == 3 && !wdata[12] && !wdata[9] && !m_brk;
      osz = txq.size();
      feed_pop = !m_txstb && osz > 0 && !m_brk;
      if (m_txstb && !tx_busy) m_txstb = 0;
      else if (feed_pop) begin m_txstb = 1; m_txdata = txq[0]; end
      acc = push_req && (osz < D || feed_pop);
      if (feed_pop) void'(txq.pop_front());
      if (acc) txq.push_back(wdata[7:0]);
      if (push_req && !acc) m_tx_ovf = 1;
      if (tx_clr) begin txq.delete(); m_tx_ovf = 0; end
      if (wr && addr == 3) m_brk = wdata[9];
    end
  end

  // ---------------- compare every clock ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      check(ack == p_ack[1], "R1 ack", 32'(ack), 32'(p_ack[1]));
      check(!stall, "R1 stall", 32'(stall), 0);
      if (p_ack[1] && !p_we[1]) begin
        case (p_addr[1])
          2'd0: check(rdata === p_rd[1], "R2 setup read", rdata, p_rd[1]);
          2'd1: check(rdata === p_rd[1], "R3 R11 status read", rdata, p_rd[1]);
          2'd2: check(rdata === p_rd[1], "R4 R5 R6 rx read", rdata, p_rd[1]);
          default: check(rdata === p_rd[1], "R7 R8 tx read", rdata, p_rd[1]);
        endcase
      end
      check(setup == m_setup, "R2 setup_o", 32'(setup), 32'(m_setup));
      check(rx_rst == m_rxrst, "R2 R6 rx_reset_o", 32'(rx_rst), 32'(m_rxrst));
      check(tx_stb == m_txstb, "R9 tx_stb_o", 32'(tx_stb), 32'(m_txstb));
      if (m_txstb) check(tx_data == m_txdata, "R9 tx_data_o", 32'(tx_data), 32'(m_txdata));
      check(tx_brk == m_brk, "R8 tx_break_o", 32'(tx_brk), 32'(m_brk));
      check(irq_rx == (rxq.size() != 0), "R10 irq_rx", 32'(irq_rx), 32'(rxq.size() != 0));
      check(irq_rxf == (rxq.size() >= D/2), "R10 irq_rxfifo", 32'(irq_rxf), 32'(rxq.size() >= D/2));
      check(irq_txf == (txq.size() < D/2), "R10 irq_txfifo", 32'(irq_txf), 32'(txq.size() < D/2));
      check(irq_tx == !m_busy(), "R10 irq_tx", 32'(irq_tx), 32'(!m_busy()));
    end
  end

  // ---------------- slow transmit engine ----------------
  int eng_cnt = 0;
  bit eng_pend = 0;
  always @(posedge clk) begin
    #3;
    if (eng_pend) begin eng_cnt = ENG_CYC; eng_pend = 0; end
    else if (eng_cnt > 0) eng_cnt--;
    tx_busy = (eng_cnt > 0);
    if (tx_stb && !tx_busy) eng_pend = 1;
  end

  // ---------------- stimulus ----------------
  task automatic bus(input bit w, input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #3;
    stb = 1; we = w; addr = a; wdata = d;
    @(posedge clk); #3;
    stb = 0; we = 0;
  endtask

  task automatic rxbyte(input logic [7:0] d, input bit p, input bit f);
    @(posedge clk); #3;
    rx_stb = 1; rx_data = d; rx_par = p; rx_frm = f;
    @(posedge clk); #3;
    rx_stb = 0; rx_par = 0; rx_frm = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    idle(3);
    // reset state of every register (R1 R2 R3 R4 R7)
    for (int a = 0; a < 4; a++) bus(0, 2'(a), 0);
    // R2: setup write and readback, clears receive path
    rxbyte(8'h99, 0, 0);
    bus(1, 0, 32'hFFFF_FFFF);
    bus(0, 0, 0);
    bus(0, 2, 0);
    // R4 R5: bytes with errors, break level
    rxbyte(8'h41, 0, 0);
    rxbyte(8'h5A, 1, 0);
    rx_brk = 1;
    rxbyte(8'hC3, 0, 1);
    bus(0, 1, 0);
    for (int i = 0; i < 4; i++) bus(0, 2, 0);
    rx_brk = 0;
    // R5: write-one clear of parity only, then frame
    bus(1, 2, 32'h0000_0200);
    bus(0, 2, 0);
    bus(1, 2, 32'h0000_0400);
    bus(0, 2, 0);
    // R5: set and clear in the same cycle, set wins
    @(posedge clk); #3;
    stb = 1; we = 1; addr = 2; wdata = 32'h0000_0200; rx_stb = 1; rx_data = 8'h07; rx_par = 1;
    @(posedge clk); #3;
    stb = 0; we = 0; rx_stb = 0; rx_par = 0;
    bus(0, 2, 0);
    bus(1, 2, 32'h0000_0200);
    // R11: write to status is ignored
    bus(1, 1, 32'hFFFF_FFFF);
    bus(0, 1, 0);
    bus(0, 2, 0);
    // R6: overflow the receive fifo
    for (int i = 0; i < D + 3; i++) rxbyte(8'(i + 8'h10), 0, 0);
    bus(0, 1, 0);
    bus(0, 2, 0);
    bus(0, 2, 0);
    bus(1, 2, 32'h0000_1000);
    bus(0, 2, 0);
    bus(0, 1, 0);
    // R8 R9: transmit bytes behind the slow engine
    bus(1, 3, 32'h11);
    bus(1, 3, 32'h22);
    bus(1, 3, 32'h33);
    bus(0, 3, 0);
    idle(40);
    bus(0, 3, 0);
    // R8: overflow the transmit fifo, then clear it
    for (int i = 0; i < D + 4; i++) bus(1, 3, 32'(8'hA0 + i));
    bus(0, 1, 0);
    bus(0, 3, 0);
    bus(1, 3, 32'h0000_1000);
    bus(0, 3, 0);
    idle(30);
    // R8: break blocks pushes and hand-off; leaving break sends nothing
    bus(1, 3, 32'h0000_0244);
    bus(0, 3, 0);
    bus(1, 3, 32'h55);
    bus(0, 3, 0);
    bus(1, 3, 32'h66);
    bus(1, 3, 32'h77);
    bus(1, 3, 32'h0000_0200);
    idle(20);
    bus(0, 3, 0);
    bus(1, 3, 32'h0);
    tx_line = 0; rx_line = 0;
    bus(0, 3, 0);
    tx_line = 1; rx_line = 1;
    idle(60);
    bus(0, 3, 0);
    bus(0, 1, 0);
    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule